// File: doc/BRIEF.md
# Stuck-Thread Counter and Barrier Gate

This block sits beside the reservation path of a hardware-managed element queue. For every read reservation it picks the final answer: grant, reject, or finish. Threads that spin in a reservation retry loop mark only their first attempt. The block uses that one bit to keep a running count of waiting threads, so it never needs thread identities. The count is compared against the number of threads still alive. When every thread is waiting and nothing is readable, a rejection becomes a finish code that tells the requester to exit.

The same count also drives a global barrier. A bar bit is carried at a configurable position inside each element. The gate lets a read through only while the bar of the next readable element equals the current barrier value. When all live threads end up waiting behind a barrier, the block takes over the new bar value and releases reads. A coalesced request that cannot be filled completely while everything is stuck is partly granted, and the response reports the smaller count. The queue storage is outside this block.

Top module: `lb_sync_gate`

## Requirements
- R1: After reset, or in the cycle after `cfg_load`, `waiting` is 0 and `barrier_val` is 0. `threads_left` is 0 after reset and `cfg_threads` after a load. `rsp_valid` is low in that cycle.
- R2: A request sampled with `req_valid` high (and `cfg_load` low) produces `rsp_valid` high for exactly one cycle, at the next clock edge. `rsp_kind` encodes 0 = reject, 1 = grant, 2 = finish.
- R3: If the bar check passes and `buf_avail >= req_cnt`, the response is a grant of `req_cnt`. A granted first attempt leaves `waiting` unchanged. A granted retry lowers `waiting` by `req_cnt`.
- R4: In a plain rejection, `rsp_cnt` is 0. A first attempt raises `waiting` by `req_cnt`, and a retry leaves it unchanged.
- R5: Let the tentative count be `waiting` after the R4 increment. If the request is not grantable under R3, the tentative count is at least `threads_left`, and `buf_avail` is 0, the response is finish with `rsp_cnt = req_cnt`. `threads_left` then drops by `req_cnt`, saturating at 0, and `waiting` takes the tentative count.
- R6: If the request is not grantable under R3, the tentative count is at least `threads_left`, and `buf_avail > 0`, the response is a grant of min(`req_cnt`, `buf_avail`). `waiting` becomes tentative minus the granted count.
- R7: With `cfg_bar_en` high, a request whose element bar differs from `barrier_val` is rejected under R4 unless R6 applies.
- R8: When R6 applies with `cfg_bar_en` high and a bar mismatch, `barrier_val` takes the element's bar in the same update as the grant. Otherwise `barrier_val` only changes on load.
- R9: With `cfg_bar_en` low, the bar never blocks a grant.
- R10: The element bar is bit `cfg_bar_pos` of `head_data`. It is captured on the first cycle with `buf_avail > 0` for a new `head_seq`. Later changes of `head_data` under the same `head_seq` are ignored.
- R11: `waiting` saturates at 0 when lowered below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load thread total, clear waiting count and barrier value |
| cfg_threads | input | THR_W | Number of live threads to load |
| cfg_bar_en | input | 1 | Enable barrier gating |
| cfg_bar_pos | input | POS_W | Bit index of the bar inside an element |
| req_valid | input | 1 | Read reservation present |
| req_first | input | 1 | Request is the first attempt of its retry loop |
| req_cnt | input | CNT_W | Number of elements (threads) in the request |
| buf_avail | input | CNT_W | Readable elements currently in the queue |
| head_data | input | DATA_W | Contents of the next readable element |
| head_seq | input | SEQ_W | Tag identifying the next readable element |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 reject, 1 grant, 2 finish |
| rsp_cnt | output | CNT_W | Granted or finished count |
| waiting | output | THR_W | Current stuck-thread count |
| threads_left | output | THR_W | Live thread total |
| barrier_val | output | 1 | Current barrier value |

## Verification
Every result depends on a single register stage. The response, `waiting`, `threads_left` and `barrier_val` all change at the first rising edge after the request is sampled. The bench drives each request at a falling edge and compares all five results at the following falling edge. The bar cache is written at that same edge, so cached-bar behaviour shows up only on the next request with the same tag. The directed test spaces its requests one cycle apart for that reason. The sweep moves to a fresh tag for every request, so the bar it checks is always the live one.

// File: rtl/lb_sync_pkg.sv
package lb_sync_pkg;

    typedef enum logic [1:0] {
        RSP_REJECT = 2'd0,
        RSP_GRANT  = 2'd1,
        RSP_FINISH = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/lb_bar_cache.sv
module lb_bar_cache #(
    parameter int DATA_W = 8,
    parameter int SEQ_W  = 8,
    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_ok,
    input  logic [DATA_W-1:0] head_data,
    input  logic [SEQ_W-1:0]  head_seq,
    input  logic [POS_W-1:0]  bar_pos,
    output logic              bar_now
);
    typedef struct packed {
        logic             vld;
        logic [SEQ_W-1:0] seq;
        logic             bar;
    } cache_t;

    cache_t st_q, st_d;
    logic   hit;

    always_comb begin
        hit     = st_q.vld && (st_q.seq == head_seq);
        bar_now = hit ? st_q.bar : head_data[bar_pos];
        st_d    = st_q;
        if (head_ok && !hit) begin
            st_d.vld = 1'b1;
            st_d.seq = head_seq;
            st_d.bar = head_data[bar_pos];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (head_ok && hit) |=> (st_q.bar == $past(st_q.bar))) else $error("cache"); // R10
endmodule

// File: rtl/lb_sync_decide.sv
module lb_sync_decide
    import lb_sync_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int THR_W = 8
) (
    input  logic             first,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] avail,
    input  logic             bar_match,
    input  logic [THR_W-1:0] wait_cur,
    input  logic [THR_W-1:0] total_cur,
    output rsp_kind_e        kind,
    output logic [CNT_W-1:0] gcnt,
    output logic [THR_W-1:0] wait_nx,
    output logic [THR_W-1:0] total_nx,
    output logic             load_bar
);
    function automatic logic [THR_W-1:0] sat_add(input logic [THR_W-1:0] a, input logic [CNT_W-1:0] b);
        logic [THR_W:0] s;
        s = (THR_W+1)'(a) + (THR_W+1)'(b);
        return s[THR_W] ? '1 : s[THR_W-1:0];
    endfunction

    function automatic logic [THR_W-1:0] sat_sub(input logic [THR_W-1:0] a, input logic [CNT_W-1:0] b);
        return (a >= THR_W'(b)) ? (a - THR_W'(b)) : '0;
    endfunction

    logic [THR_W-1:0] tent;
    logic [CNT_W-1:0] take;
    logic             normal_ok;
    logic             all_stuck;

    always_comb begin
        tent      = first ? sat_add(wait_cur, cnt) : wait_cur;
        take      = (cnt < avail) ? cnt : avail;
        normal_ok = bar_match && (avail >= cnt);
        all_stuck = tent >= total_cur;
        kind      = RSP_REJECT;
        gcnt      = '0;
        wait_nx   = tent;
        total_nx  = total_cur;
        load_bar  = 1'b0;
        if (normal_ok) begin
            kind    = RSP_GRANT;
            gcnt    = cnt;
            wait_nx = first ? wait_cur : sat_sub(wait_cur, cnt);
        end else if (all_stuck && (avail == '0)) begin
            kind     = RSP_FINISH;
            gcnt     = cnt;
            total_nx = sat_sub(total_cur, cnt);
        end else if (all_stuck) begin
            kind     = RSP_GRANT;
            gcnt     = take;
            load_bar = !bar_match;
            wait_nx  = first ? sat_add(wait_cur, cnt - take) : sat_sub(wait_cur, take);
        end
    end
endmodule

// File: rtl/lb_sync_gate.sv
module lb_sync_gate
    import lb_sync_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEQ_W  = 8,
    parameter int CNT_W  = 4,
    parameter int THR_W  = 8,
    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [THR_W-1:0]  cfg_threads,
    input  logic              cfg_bar_en,
    input  logic [POS_W-1:0]  cfg_bar_pos,
    input  logic              req_valid,
    input  logic              req_first,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic [CNT_W-1:0]  buf_avail,
    input  logic [DATA_W-1:0] head_data,
    input  logic [SEQ_W-1:0]  head_seq,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [CNT_W-1:0]  rsp_cnt,
    output logic [THR_W-1:0]  waiting,
    output logic [THR_W-1:0]  threads_left,
    output logic              barrier_val
);
    typedef struct packed {
        logic [THR_W-1:0] total;
        logic [THR_W-1:0] wait_n;
        logic             cbar;
        logic             vld;
        rsp_kind_e        kind;
        logic [CNT_W-1:0] cnt;
    } gate_t;

    gate_t st_q, st_d;

    logic             bar_now;
    logic             bar_match;
    rsp_kind_e        dec_kind;
    logic [CNT_W-1:0] dec_cnt;
    logic [THR_W-1:0] dec_wait;
    logic [THR_W-1:0] dec_total;
    logic             dec_load;

    lb_bar_cache #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) bar_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_ok   (buf_avail != '0),
        .head_data (head_data),
        .head_seq  (head_seq),
        .bar_pos   (cfg_bar_pos),
        .bar_now   (bar_now)
    );

    assign bar_match = !cfg_bar_en || (bar_now == st_q.cbar);

    lb_sync_decide #(.CNT_W(CNT_W), .THR_W(THR_W)) dec_i (
        .first     (req_first),
        .cnt       (req_cnt),
        .avail     (buf_avail),
        .bar_match (bar_match),
        .wait_cur  (st_q.wait_n),
        .total_cur (st_q.total),
        .kind      (dec_kind),
        .gcnt      (dec_cnt),
        .wait_nx   (dec_wait),
        .total_nx  (dec_total),
        .load_bar  (dec_load)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.kind = RSP_REJECT;
        st_d.cnt  = '0;
        if (cfg_load) begin
            st_d.total  = cfg_threads;
            st_d.wait_n = '0;
            st_d.cbar   = 1'b0;
        end else if (req_valid) begin
            st_d.vld    = 1'b1;
            st_d.kind   = dec_kind;
            st_d.cnt    = dec_cnt;
            st_d.wait_n = dec_wait;
            st_d.total  = dec_total;
            if (dec_load) st_d.cbar = bar_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.vld;
    assign rsp_kind     = st_q.kind;
    assign rsp_cnt      = st_q.cnt;
    assign waiting      = st_q.wait_n;
    assign threads_left = st_q.total;
    assign barrier_val  = st_q.cbar;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_load) |=> rsp_valid) else $error("rsp"); // R2
    AST_NO_FINISH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_load && buf_avail != '0) |=> (rsp_kind != 2'd2)) else $error("fin"); // R5
    AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_load) |=> (rsp_cnt <= $past(req_cnt))) else $error("bound"); // R6
    AST_TOTAL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> (threads_left <= $past(threads_left))) else $error("total"); // R5
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_load && !cfg_bar_en && req_cnt != '0 && buf_avail >= req_cnt)
        |=> (rsp_kind == 2'd1 && rsp_cnt == $past(req_cnt))) else $error("bypass"); // R9
endmodule

// File: tb/lb_sync_gate_tb.sv
module lb_sync_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_threads = '0;
    logic       cfg_bar_en = 1'b0;
    logic [2:0] cfg_bar_pos = '0;
    logic       req_valid = 1'b0;
    logic       req_first = 1'b0;
    logic [3:0] req_cnt = '0;
    logic [3:0] buf_avail = '0;
    logic [7:0] head_data = '0;
    logic [7:0] head_seq = '0;
    logic       rsp_valid;
    logic [1:0] rsp_kind;
    logic [3:0] rsp_cnt;
    logic [7:0] waiting;
    logic [7:0] threads_left;
    logic       barrier_val;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] seq_ctr = 8'd1;

    always #5 clk = ~clk;

    lb_sync_gate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_threads(cfg_threads),
        .cfg_bar_en(cfg_bar_en), .cfg_bar_pos(cfg_bar_pos), .req_valid(req_valid),
        .req_first(req_first), .req_cnt(req_cnt), .buf_avail(buf_avail),
        .head_data(head_data), .head_seq(head_seq), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_cnt(rsp_cnt), .waiting(waiting),
        .threads_left(threads_left), .barrier_val(barrier_val)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input int t);
        @(negedge clk);
        cfg_load = 1'b1; cfg_threads = 8'(t);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic req(input bit f, input int c, input int a, input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_first = f; req_cnt = 4'(c); buf_avail = 4'(a);
        head_data = d; head_seq = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Expected outcome from the requirement text
    task automatic expect_of(input bit f, input int c, input int a, input bit ok_bar,
                             input int w, input int t, input int cb, input int bar,
                             output int ek, output int ec, output int ew, output int et, output int ecb);
        int tent;
        int g;
        tent = f ? w + c : w;
        ek = 0; ec = 0; ew = tent; et = t; ecb = cb;
        if (ok_bar && a >= c) begin
            ek = 1; ec = c; ew = f ? w : ((w > c) ? w - c : 0);
        end else if (tent >= t && a == 0) begin
            ek = 2; ec = c; et = (t > c) ? t - c : 0;
        end else if (tent >= t) begin
            g = (c < a) ? c : a;
            ek = 1; ec = g; ew = (tent > g) ? tent - g : 0;
            if (!ok_bar) ecb = bar;
        end
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int ek, ec, ew, et, ecb;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(waiting == 0, "R1 waiting", waiting, 0);
        chk(threads_left == 0, "R1 total", threads_left, 0);
        chk(barrier_val == 0, "R1 cbar", barrier_val, 0);

        // R2: single-cycle response
        load(5);
        chk(threads_left == 5, "R1 load total", threads_left, 5);
        req(1'b1, 2, 4, 8'h00, seq_ctr); seq_ctr++;
        chk(rsp_valid == 1'b1, "R2 valid", rsp_valid, 1);
        chk(rsp_kind == 1, "R3 grant", rsp_kind, 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 one cycle", rsp_valid, 0);

        // R10: bar cached per tag
        load(9); cfg_bar_en = 1'b1; cfg_bar_pos = 3'd3;
        req(1'b1, 1, 2, 8'h08, 8'd200);
        chk(rsp_kind == 0, "R7 mismatch reject", rsp_kind, 0);
        req(1'b1, 1, 2, 8'hF7, 8'd200);
        chk(rsp_kind == 0, "R10 cached bar", rsp_kind, 0);
        req(1'b0, 1, 2, 8'hF7, 8'd201);
        chk(rsp_kind == 1, "R10 new tag", rsp_kind, 1);
        chk(waiting == 1, "R3 retry lowers", waiting, 1);

        // R5: finish chain with retries
        load(2); cfg_bar_en = 1'b0;
        req(1'b1, 1, 0, 8'h00, 8'd0);
        chk(rsp_kind == 0 && waiting == 1, "R4 first reject", waiting, 1);
        req(1'b1, 1, 0, 8'h00, 8'd0);
        chk(rsp_kind == 2, "R5 finish", rsp_kind, 2);
        chk(threads_left == 1, "R5 total", threads_left, 1);
        req(1'b0, 1, 0, 8'h00, 8'd0);
        chk(rsp_kind == 2 && threads_left == 0, "R5 retry finish", threads_left, 0);

        // Sweep
        for (int t = 2; t <= 3; t++)
          for (int pre = 0; pre < t; pre++)
            for (int f = 0; f <= 1; f++)
              for (int c = 1; c <= 4; c++)
                for (int a = 0; a <= 4; a++)
                  for (int b = 0; b <= 1; b++)
                    for (int e = 0; e <= 1; e++) begin
                        load(t);
                        cfg_bar_en = e[0];
                        cfg_bar_pos = 3'((c + a) % 8);
                        if (pre > 0) begin
                            req(1'b1, pre, 0, 8'h00, seq_ctr); seq_ctr++;
                        end
                        d = b[0] ? (8'd1 << cfg_bar_pos) : ~(8'd1 << cfg_bar_pos);
                        expect_of(f[0], c, a, (e == 0) || (b == 0), pre, t, 0, b,
                                  ek, ec, ew, et, ecb);
                        req(f[0], c, a, d, seq_ctr); seq_ctr++;
                        chk(rsp_kind == 2'(ek), "R3/R4/R5/R6/R7/R9 kind", rsp_kind, ek);
                        chk(rsp_cnt == 4'(ec), "R3/R6 count", rsp_cnt, ec);
                        chk(waiting == 8'(ew), "R4/R6/R11 waiting", waiting, ew);
                        chk(threads_left == 8'(et), "R5 total", threads_left, et);
                        chk(barrier_val == ecb[0], "R8 barrier", barrier_val, ecb);
                    end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule